// File: doc/BRIEF.md
# Slot-Spread PWM Output Channel

This block drives one pulse-width-modulated output pin. A frame of 2^N ticks is counted on a tick-enable input that stands in for whichever PWM clock the chip has selected upstream. N, the resolution, is set by a 4-bit code and ranges from 7 to 16. A duty value gives the number of high ticks in each frame.

The block can also spread that high time. Each frame is cut into S equal slots, and every slot starts with its share of the duty. The output then toggles several times per frame rather than giving one long pulse, which moves ripple energy to a higher frequency and relaxes the filter that follows the pin. A 2-bit spreading code sets S. The block also has an invert control. It runs only when both its own enable and a chip-wide master enable are set.

Duty and configuration are copied into shadow registers only at a frame boundary, or at any time while the channel is disabled, so a change in mid-frame never truncates or stretches a pulse.

Top module: `pwm_spread_chan`

## Requirements
- R1: The resolution code c selects N = 7 + c for c = 0 to 8, and N = 16 for c = 9 to 15. With the tick input held high, one frame lasts 2^N clock cycles.
- R2: The spreading code p (0 to 3) gives S = 2^(N - 10 + p) slots per frame when N > 10 - p, and S = 1 otherwise. Each slot lasts 2^N / S ticks.
- R3: For a latched duty D, with q = floor(D/S) and r = D mod S, slot k is high for its first q ticks, plus one more tick when k < r. The total high time per frame is exactly D.
- R4: A duty of 0 keeps the output at its low level for the whole frame. A duty of 2^N or more is clamped to 2^N and keeps the output at its high level for the whole frame (both before inversion).
- R5: The channel runs only while both the local enable and the master enable are 1. Otherwise the frame position is held at 0 and the pin sits at its inactive level: 0, or 1 when invert is set. After enabling, the first frame starts at position 0.
- R6: When the invert input is 1, the pin is the complement of the level defined by R3 and R4.
- R7: While the channel is enabled, the invert, resolution, spreading and duty inputs are taken only when the last position of a frame advances. A change in mid-frame first affects the following frame. While disabled they are taken every cycle.
- R8: The frame position advances only on clock edges where the tick input is 1. With the tick held at 0, the pin holds its level.
- R9: During and after reset the pin is 0 and the configuration is N = 7, S = 1, duty 0, no inversion. The pin is registered and shows the level for the current frame position one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_invert | input | 1 | Invert the final pin level |
| cfg_local_en | input | 1 | Channel's own enable |
| cfg_res_code | input | 4 | Resolution code (N = 7 + code, saturating at 16) |
| cfg_spread_code | input | 2 | Spreading code setting the slot count |
| master_en | input | 1 | Chip-wide PWM enable |
| duty | input | 17 | High ticks per frame, 0 to 2^N |
| tick_en | input | 1 | Advance the frame position on this edge |
| pwm_out | output | 1 | Registered PWM pin |

## Verification
The bench goes after the remainder slots: a duty smaller than the slot count must give single-tick pulses in only the first D mod S slots. A design that rounds per slot instead would lose or add high ticks, and the per-frame high count and rising-edge count would show it. It also checks the clamped extremes (zero duty, and duty above 2^N at the shortest frame) and the saturating resolution codes, where a wrong mapping would change the frame length. Finally it changes the duty in mid-frame and expects the old value for the rest of that frame; a design that latches at once would give a mixed high count. Random runs with a gapped tick and toggled enables are compared cycle by cycle against a model of the requirements, which catches a position that moves without a tick or fails to restart at zero.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;
  localparam int PWM_MAX_RES     = 16;
  localparam int PWM_MIN_RES     = 7;
  localparam int PWM_SPREAD_BASE = 10;
  localparam int PWM_CODE_W      = 4;
  localparam int PWM_PS_W        = 2;
  localparam int PWM_RES_W       = $clog2(PWM_MAX_RES + 1);

  // Frame-level settings latched together at a frame boundary
  typedef struct packed {
    logic                 inv;
    logic [PWM_RES_W-1:0] res_n;
    logic [PWM_PS_W-1:0]  spread;
  } pwm_frame_cfg_t;
endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
  import pwm_spread_pkg::*;
#(
  parameter int MAX_RES = PWM_MAX_RES,
  parameter int MIN_RES = PWM_MIN_RES,
  parameter int CODE_W  = PWM_CODE_W,
  parameter int PS_W    = PWM_PS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              in_invert,
  input  logic [CODE_W-1:0] in_res_code,
  input  logic [PS_W-1:0]   in_spread,
  input  logic [MAX_RES:0]  in_duty,
  output pwm_frame_cfg_t    sh_cfg,
  output logic [MAX_RES:0]  sh_duty
);
  localparam int DW    = MAX_RES + 1;
  localparam int STEPS = MAX_RES - MIN_RES;

  logic [PWM_RES_W-1:0] new_n;
  logic [DW-1:0]        new_len;
  logic [DW-1:0]        new_duty;

  // Resolution decode saturates at MAX_RES; duty clamps to one full frame
  always_comb begin
    if (int'(in_res_code) >= STEPS) new_n = PWM_RES_W'(MAX_RES);
    else                            new_n = PWM_RES_W'(MIN_RES) + PWM_RES_W'(in_res_code);
    new_len  = DW'(1) << new_n;
    new_duty = (in_duty > new_len) ? new_len : in_duty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg.inv    <= 1'b0;
      sh_cfg.res_n  <= PWM_RES_W'(MIN_RES);
      sh_cfg.spread <= '0;
      sh_duty       <= '0;
    end else if (load) begin
      sh_cfg.inv    <= in_invert;
      sh_cfg.res_n  <= new_n;
      sh_cfg.spread <= in_spread;
      sh_duty       <= new_duty;
    end
  end

  assert_duty_clamped_R4: assert property (@(posedge clk) disable iff (rst)
    sh_duty <= (DW'(1) << sh_cfg.res_n));

  assert_res_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(sh_cfg.res_n) >= MIN_RES) && (int'(sh_cfg.res_n) <= MAX_RES));
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr
  import pwm_spread_pkg::*;
#(
  parameter int MAX_RES = PWM_MAX_RES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tick,
  input  logic [PWM_RES_W-1:0] res_n,
  output logic [MAX_RES-1:0]   pos,
  output logic                 wrap
);
  localparam int DW = MAX_RES + 1;

  logic [DW-1:0] frame_len;
  logic [DW-1:0] last_full;
  logic          at_last;

  always_comb begin
    frame_len = DW'(1) << res_n;
    last_full = frame_len - DW'(1);
    at_last   = (pos == last_full[MAX_RES-1:0]);
    wrap      = en & tick & at_last;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  pos <= '0;
    else if (tick)   pos <= at_last ? '0 : pos + 1'b1;
  end

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pos == '0));

  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(pos));

  assert_pos_in_frame_R1: assert property (@(posedge clk) disable iff (rst)
    DW'(pos) < frame_len);
endmodule

// File: rtl/pwm_slot_cmp.sv
module pwm_slot_cmp
  import pwm_spread_pkg::*;
#(
  parameter int MAX_RES     = PWM_MAX_RES,
  parameter int SPREAD_BASE = PWM_SPREAD_BASE,
  parameter int PS_W        = PWM_PS_W
) (
  input  logic [MAX_RES-1:0]   pos,
  input  logic [PWM_RES_W-1:0] res_n,
  input  logic [PS_W-1:0]      spread,
  input  logic [MAX_RES:0]     duty,
  output logic                 level
);
  localparam int DW = MAX_RES + 1;

  logic [PWM_RES_W-1:0] div_exp;
  logic [PWM_RES_W-1:0] lg_len;
  logic [PWM_RES_W-1:0] lg_slots;
  logic [DW-1:0]        slot_idx;
  logic [DW-1:0]        offset;
  logic [DW-1:0]        per_slot;
  logic [DW-1:0]        extra_cnt;
  logic [DW-1:0]        high_len;

  // Slot length is 2^min(N, BASE - p); the rest of N's bits index the slot
  always_comb begin
    div_exp   = PWM_RES_W'(SPREAD_BASE) - PWM_RES_W'(spread);
    lg_len    = (res_n < div_exp) ? res_n : div_exp;
    lg_slots  = res_n - lg_len;
    slot_idx  = DW'(pos) >> lg_len;
    offset    = DW'(pos) & ((DW'(1) << lg_len) - DW'(1));
    per_slot  = duty >> lg_slots;
    extra_cnt = duty & ((DW'(1) << lg_slots) - DW'(1));
    high_len  = per_slot + DW'(slot_idx < extra_cnt);
    level     = (offset < high_len);
  end
endmodule

// File: rtl/pwm_spread_chan.sv
module pwm_spread_chan
  import pwm_spread_pkg::*;
#(
  parameter int MAX_RES     = PWM_MAX_RES,
  parameter int MIN_RES     = PWM_MIN_RES,
  parameter int SPREAD_BASE = PWM_SPREAD_BASE,
  parameter int CODE_W      = PWM_CODE_W,
  parameter int PS_W        = PWM_PS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_invert,
  input  logic              cfg_local_en,
  input  logic [CODE_W-1:0] cfg_res_code,
  input  logic [PS_W-1:0]   cfg_spread_code,
  input  logic              master_en,
  input  logic [MAX_RES:0]  duty,
  input  logic              tick_en,
  output logic              pwm_out
);
  localparam int DW = MAX_RES + 1;

  logic               chan_en;
  logic               frame_wrap;
  logic               shadow_load;
  logic [MAX_RES-1:0] frame_pos;
  logic               raw_level;
  pwm_frame_cfg_t     sh_cfg;
  logic [DW-1:0]      sh_duty;

  assign chan_en     = cfg_local_en & master_en;
  assign shadow_load = ~chan_en | frame_wrap;

  pwm_cfg_shadow #(
    .MAX_RES(MAX_RES), .MIN_RES(MIN_RES), .CODE_W(CODE_W), .PS_W(PS_W)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(shadow_load),
    .in_invert(cfg_invert), .in_res_code(cfg_res_code),
    .in_spread(cfg_spread_code), .in_duty(duty),
    .sh_cfg(sh_cfg), .sh_duty(sh_duty)
  );

  pwm_frame_ctr #(.MAX_RES(MAX_RES)) u_ctr (
    .clk(clk), .rst(rst), .en(chan_en), .tick(tick_en),
    .res_n(sh_cfg.res_n), .pos(frame_pos), .wrap(frame_wrap)
  );

  pwm_slot_cmp #(
    .MAX_RES(MAX_RES), .SPREAD_BASE(SPREAD_BASE), .PS_W(PS_W)
  ) u_cmp (
    .pos(frame_pos), .res_n(sh_cfg.res_n), .spread(sh_cfg.spread),
    .duty(sh_duty), .level(raw_level)
  );

  always_ff @(posedge clk) begin
    if (rst)           pwm_out <= 1'b0;
    else if (!chan_en) pwm_out <= cfg_invert;
    else               pwm_out <= raw_level ^ sh_cfg.inv;
  end

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (pwm_out == $past(cfg_invert)));

  assert_latch_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !frame_wrap) |=> ($stable(sh_duty) && $stable(sh_cfg)));

  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (chan_en && sh_duty == '0) |=> (pwm_out == $past(sh_cfg.inv)));

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (chan_en && sh_duty == (DW'(1) << sh_cfg.res_n)) |=> (pwm_out == !$past(sh_cfg.inv)));
endmodule

// File: tb/pwm_spread_chan_tb.sv
module pwm_spread_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        r_inv = 1'b0, r_le = 1'b0, r_me = 1'b0, r_tick = 1'b0;
  logic [3:0]  r_code = '0;
  logic [1:0]  r_ps = '0;
  logic [16:0] r_duty = '0;
  logic        pwm_out;

  int    checks = 0;
  int    fails  = 0;
  bit    cyc_check = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R9";

  // reference state
  int m_pos = 0, m_n = 7, m_ps = 0, m_d = 0;
  bit m_inv = 1'b0, m_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_spread_chan u_dut (
    .clk(clk), .rst(rst), .cfg_invert(r_inv), .cfg_local_en(r_le),
    .cfg_res_code(r_code), .cfg_spread_code(r_ps), .master_en(r_me),
    .duty(r_duty), .tick_en(r_tick), .pwm_out(pwm_out)
  );

  function automatic int code_to_n(int c);
    return (c >= 9) ? 16 : 7 + c;
  endfunction

  function automatic int slots_of(int n, int ps);
    return (n > 10 - ps) ? (1 << (n - 10 + ps)) : 1;
  endfunction

  function automatic int clamp_duty(int d, int n);
    return (d > (1 << n)) ? (1 << n) : d;
  endfunction

  function automatic bit exp_level(int p, int n, int ps, int d);
    int s, l, k, o, q, r;
    s = slots_of(n, ps);
    l = (1 << n) / s;
    k = p / l;
    o = p % l;
    q = d / s;
    r = d % s;
    return (o < q + ((k < r) ? 1 : 0));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_load();
    m_n   = code_to_n(int'(r_code));
    m_ps  = int'(r_ps);
    m_d   = clamp_duty(int'(r_duty), m_n);
    m_inv = r_inv;
  endtask

  // Reference built from R1..R9
  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_n = 7; m_ps = 0; m_d = 0; m_inv = 1'b0; m_out = 1'b0;
    end else if (!(r_le && r_me)) begin
      m_pos = 0;
      model_load();
      m_out = r_inv;
    end else begin
      m_out = exp_level(m_pos, m_n, m_ps, m_d) ^ m_inv;
      if (r_tick) begin
        if (m_pos == (1 << m_n) - 1) begin
          m_pos = 0;
          model_load();
        end else begin
          m_pos++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cyc_check && !rst) check(pwm_out == m_out, cur_tag, int'(pwm_out), int'(m_out));
  end

  task automatic frame_count(input int code, input int ps, input bit inv,
                             input int d1, input int d2, input int change_at,
                             input int frames, input int exp_rises, input string tag);
    int n, len, cnt, rises, e;
    bit prev, lvl;
    n   = code_to_n(code);
    len = 1 << n;
    cur_tag = tag;
    @(negedge clk);
    r_le = 1'b0; r_me = 1'b1; r_code = 4'(code); r_ps = 2'(ps);
    r_inv = inv; r_duty = 17'(d1); r_tick = 1'b1;
    @(negedge clk);
    r_le = 1'b1;
    for (int f = 0; f < frames; f++) begin
      cnt = 0; rises = 0; prev = 1'b0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        lvl = pwm_out ^ inv;
        if (lvl) cnt++;
        if (lvl && !prev) rises++;
        prev = lvl;
        if (f == 0 && i == change_at) r_duty = 17'(d2);
      end
      e = clamp_duty((f == 0) ? d1 : d2, n);
      check(cnt == e, {tag, " high ticks per frame"}, cnt, e);
      if (f == 0 && exp_rises >= 0)
        check(rises == exp_rises, {tag, " pulses per frame"}, rises, exp_rises);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit held;
    int n, len, runlen;
    void'($urandom(32'h00C0FFEE));

    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      check(pwm_out == 1'b0, "R9 pin low in reset", int'(pwm_out), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 pin low after reset", int'(pwm_out), 0);
    cyc_check = 1'b1;

    // R1 / R2 / R3 / R4 / R6 / R7 directed frames
    frame_count(0, 0, 1'b0, 40, 40, -1, 1, 1, "R1 N=7 single pulse");
    frame_count(2, 0, 1'b0, 100, 100, -1, 1, 1, "R2 N=9 code00 one slot");
    frame_count(4, 1, 1'b0, 1500, 1500, -1, 1, 4, "R2 N=11 code01 four slots");
    frame_count(5, 2, 1'b0, 1000, 1000, -1, 1, 16, "R2 N=12 code10 sixteen slots");
    frame_count(3, 3, 1'b0, 300, 300, -1, 1, 8, "R2 N=10 code11 eight slots");
    frame_count(1, 3, 1'b0, 37, 37, -1, 1, 2, "R3 odd remainder");
    frame_count(3, 3, 1'b0, 3, 3, -1, 1, 3, "R3 duty below slot count");
    frame_count(0, 3, 1'b0, 0, 0, -1, 1, 0, "R4 zero duty");
    frame_count(0, 1, 1'b0, 133, 133, -1, 1, 1, "R4 duty clamp");
    frame_count(6, 2, 1'b0, 8192, 8192, -1, 1, 1, "R4 full duty N=13");
    frame_count(2, 1, 1'b1, 200, 200, -1, 1, -1, "R6 inverted");
    frame_count(1, 0, 1'b0, 50, 200, 30, 2, -1, "R7 mid-frame duty change");

    // R5: master enable off keeps the inactive level
    cur_tag = "R5 idle level";
    @(negedge clk);
    r_le = 1'b1; r_me = 1'b0; r_inv = 1'b1; r_duty = 17'd64; r_code = 4'd0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(pwm_out == 1'b1, "R5 disabled inverted pin high", int'(pwm_out), 1);
    end
    r_me = 1'b1; r_le = 1'b0; r_inv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pwm_out == 1'b0, "R5 local disable pin low", int'(pwm_out), 0);

    // R8: tick held low freezes the pin
    cur_tag = "R8 tick gate";
    r_code = 4'd0; r_ps = 2'd0; r_duty = 17'd64; r_tick = 1'b1;
    @(negedge clk);
    r_le = 1'b1;
    repeat (10) @(negedge clk);
    r_tick = 1'b0;
    @(negedge clk);
    held = pwm_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(pwm_out == held, "R8 pin frozen without tick", int'(pwm_out), int'(held));
    end

    // R1: saturating resolution code, N=16
    frame_count(13, 3, 1'b0, 40000, 40000, -1, 1, 512, "R1 code 13 gives N=16");

    // Random segments checked cycle by cycle (R3 R5 R7 R8)
    cur_tag = "R3 R5 R7 R8 random";
    for (int seg = 0; seg < 12; seg++) begin
      @(negedge clk);
      r_code = 4'($urandom_range(0, 3));
      r_ps   = 2'($urandom_range(0, 3));
      n      = code_to_n(int'(r_code));
      len    = 1 << n;
      case ($urandom_range(0, 9))
        0:       r_duty = 17'd0;
        1:       r_duty = 17'(len + 2);
        default: r_duty = 17'($urandom_range(0, len));
      endcase
      r_inv  = 1'($urandom_range(0, 1));
      r_le   = ($urandom_range(0, 7) != 0);
      r_me   = ($urandom_range(0, 7) != 0);
      runlen = $urandom_range(400, 1400);
      for (int i = 0; i < runlen; i++) begin
        @(negedge clk);
        r_tick = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 199) == 0) r_duty = 17'($urandom_range(0, len));
        if ($urandom_range(0, 299) == 0) r_ps = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 399) == 0) r_inv = ~r_inv;
        if ($urandom_range(0, 499) == 0) r_me = ~r_me;
      end
    end

    cyc_check = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule